// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block holds the programmable state of an interrupt router behind a small memory-mapped window. Software first writes a register number into a select register, then reads or writes the chosen register through a data window. Behind the window sit a 4-bit identification register, a read-only version register, and one 64-bit routing entry per interrupt pin. Each entry is reached as two 32-bit halves. A third offset takes end-of-interrupt writes and forwards the vector to the servicing logic.

Every field of every routing entry is exported in parallel to the interrupt servicing logic: vector, delivery mode, destination mode, polarity, trigger mode, mask, destination and remote-pending flag. The servicing logic sets and clears the remote-pending flags through its own inputs. After each accepted entry write, the block raises a one-cycle update pulse carrying the pin index, so that the servicing logic can re-evaluate that pin. The block does not deliver interrupts and does not decode addresses outside its own window.

Top module: `irq_route_regfile`

## Requirements
- R1: After reset, every entry has its mask bit set and all other fields zero. The select register and the identification register are zero.
- R2: An accepted write at offset 0x00 loads bus_wdata[7:0] into the select register. A read at offset 0x00 returns the select register in bits 7:0 and zero in all other bits.
- R3: A window read with select 0x01 returns (PINS-1) in bits 23:16 and VERSION in bits 7:0, with all other bits zero. Window writes with select 0x01 change nothing.
- R4: A window write with select 0x00 stores bus_wdata[27:24] as the ID. Window reads with select 0x00 or 0x02 return the ID in bits 27:24 and zero elsewhere. Window writes with select 0x02 change nothing.
- R5: A select value of 0x10 or above addresses entry (select-0x10)>>1. An even select reaches the low half and an odd select reaches the high half. Low-half layout: vector 7:0, delivery mode 10:8, destination mode 11, polarity 13, remote-pending 14 (read-only), trigger 15, mask 16. Bits 12 and 31:17 read as zero. High-half layout: destination in bits 31:24, other bits zero.
- R6: A pulse on svc_rpend_set[i] sets the remote-pending flag of entry i, and a pulse on svc_rpend_clr[i] clears it; set wins if both arrive together. A low-half write to entry i clears its flag, and this takes priority over a set in the same cycle. A high-half write leaves the flag unchanged.
- R7: A window write whose entry index is PINS or more is discarded and raises no update pulse. Window reads of such indices, and of select values 0x03 to 0x0F, return zero.
- R8: An access whose bus_addr[3:0] is not zero is ignored; if it is a read, it returns zero. A write whose bus_size is not 4 or 8 has no effect.
- R9: An accepted write at offset 0x40 raises eoi_valid for exactly the next cycle, with eoi_vector equal to bus_wdata[7:0].
- R10: Each accepted entry write, to either half, raises upd_pulse for exactly the next cycle, with upd_index equal to the entry index. Updated entry fields appear on the outputs in that same cycle.
- R11: Every read raises bus_rvalid in the next cycle, with bus_rdata valid in that cycle. A read at any offset other than 0x00 or 0x10 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset inside the device window |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| bus_rvalid | output | 1 | Read data valid |
| svc_rpend_set | input | PINS | Set remote-pending flag per pin |
| svc_rpend_clr | input | PINS | Clear remote-pending flag per pin |
| ent_vector | output | PINS*8 | Vector field per pin |
| ent_dmode | output | PINS*3 | Delivery mode per pin |
| ent_destmode | output | PINS | Destination mode per pin |
| ent_pol | output | PINS | Polarity per pin |
| ent_trig | output | PINS | Trigger mode per pin (1 = level) |
| ent_mask | output | PINS | Mask per pin |
| ent_rpend | output | PINS | Remote-pending flag per pin |
| ent_dest | output | PINS*8 | Destination per pin |
| upd_pulse | output | 1 | Entry was just rewritten |
| upd_index | output | IDX_W | Index of the rewritten entry |
| eoi_valid | output | 1 | End-of-interrupt acknowledge |
| eoi_vector | output | 8 | Acknowledged vector |

## Verification
The properties assume that bus inputs and the servicing strobes are held at zero through reset. They also assume that software changes the select register only by an explicit write at offset 0x00, so the index sampled in the write cycle is the one the update pulse reports. The bench drives every input at the falling edge and leaves bus_valid low during reset. Random traffic stays within the legal select range plus a few indices past the last pin, so both the accepted and the discarded entry writes are covered. Misaligned and badly sized accesses appear only in directed steps, where their lack of effect is read back at the ports.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    // byte offsets inside the device window
    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    // select values reached through the window
    localparam logic [7:0] SEL_ID  = 8'h00;
    localparam logic [7:0] SEL_VER = 8'h01;
    localparam logic [7:0] SEL_ARB = 8'h02;
    localparam logic [7:0] SEL_TBL = 8'h10;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_SEL_WR,
        ACC_WIN_WR,
        ACC_EOI_WR,
        ACC_SEL_RD,
        ACC_WIN_RD,
        ACC_ZERO_RD
    } acc_e;

    typedef struct packed {
        logic [7:0] dest;
        logic       mask;
        logic       trig;
        logic       rpend;
        logic       pol;
        logic       destmode;
        logic [2:0] dmode;
        logic [7:0] vector;
    } entry_t;

    localparam entry_t ENTRY_RST = '{dest: 8'h00, mask: 1'b1, trig: 1'b0, rpend: 1'b0,
                                     pol: 1'b0, destmode: 1'b0, dmode: 3'h0, vector: 8'h00};

    // entry number addressed by a select value at or above SEL_TBL
    function automatic logic [7:0] tbl_index(input logic [7:0] sel);
        logic [7:0] off;
        off = sel - SEL_TBL;
        return {1'b0, off[7:1]};
    endfunction

    function automatic logic [31:0] entry_lo(input entry_t e);
        return {15'h0, e.mask, e.trig, e.rpend, e.pol, 1'b0, e.destmode, e.dmode, e.vector};
    endfunction

    function automatic logic [31:0] entry_hi(input entry_t e);
        return {e.dest, 24'h0};
    endfunction

endpackage

// File: rtl/irq_route_busdec.sv
module irq_route_busdec
    import irq_route_pkg::*;
(
    input  logic       valid,
    input  logic       write,
    input  logic [7:0] addr,
    input  logic [3:0] size,
    output acc_e       kind
);

    logic aligned;
    logic size_ok;

    always_comb begin
        aligned = (addr[3:0] == 4'h0);
        size_ok = (size == 4'd4) || (size == 4'd8);
        kind    = ACC_NONE;
        if (valid) begin
            if (write) begin
                if (aligned && size_ok) begin
                    case (addr)
                        OFF_SEL: kind = ACC_SEL_WR;
                        OFF_WIN: kind = ACC_WIN_WR;
                        OFF_EOI: kind = ACC_EOI_WR;
                        default: kind = ACC_NONE;
                    endcase
                end
            end else if (!aligned) begin
                kind = ACC_ZERO_RD;
            end else begin
                case (addr)
                    OFF_SEL: kind = ACC_SEL_RD;
                    OFF_WIN: kind = ACC_WIN_RD;
                    default: kind = ACC_ZERO_RD;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irq_route_pkg::*;
#(
    parameter int unsigned PINS  = 24,
    parameter int unsigned IDX_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic                 wr_hi,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [31:0]          wdata,
    input  logic [PINS-1:0]      rp_set,
    input  logic [PINS-1:0]      rp_clr,
    output entry_t [PINS-1:0]    ents
);

    // bits of the write word that no field keeps
    logic unused_wbits;
    assign unused_wbits = ^{wdata[23:17], wdata[14], wdata[12]};

    for (genvar g = 0; g < PINS; g++) begin : g_pin
        entry_t ent_d;
        entry_t ent_q;
        logic   hit;

        always_comb begin
            hit   = wr_en && (wr_idx == IDX_W'(g));
            ent_d = ent_q;
            if (rp_clr[g]) ent_d.rpend = 1'b0;
            if (rp_set[g]) ent_d.rpend = 1'b1;
            if (hit && !wr_hi) begin
                ent_d.vector   = wdata[7:0];
                ent_d.dmode    = wdata[10:8];
                ent_d.destmode = wdata[11];
                ent_d.pol      = wdata[13];
                ent_d.trig     = wdata[15];
                ent_d.mask     = wdata[16];
                ent_d.rpend    = 1'b0;
            end
            if (hit && wr_hi) begin
                ent_d.dest = wdata[31:24];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= ENTRY_RST;
            else        ent_q <= ent_d;
        end

        assign ents[g] = ent_q;
    end

endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
    import irq_route_pkg::*;
#(
    parameter int unsigned PINS    = 24,
    parameter int unsigned IDX_W   = 5,
    parameter logic [7:0]  VERSION = 8'h11
) (
    input  logic [7:0]       sel,
    input  logic [3:0]       id,
    input  entry_t [PINS-1:0] ents,
    output logic [31:0]      rdata
);

    localparam logic [7:0] LAST_PIN = 8'(PINS - 1);

    logic [7:0]       tidx;
    logic             in_tbl;
    logic [IDX_W-1:0] safe_idx;
    entry_t           pick;

    always_comb begin
        tidx     = tbl_index(sel);
        in_tbl   = (sel >= SEL_TBL) && (32'(tidx) < 32'(PINS));
        safe_idx = in_tbl ? tidx[IDX_W-1:0] : '0;
        pick     = ents[safe_idx];
        rdata    = 32'h0;
        if (sel == SEL_ID || sel == SEL_ARB) begin
            rdata = {4'h0, id, 24'h0};
        end else if (sel == SEL_VER) begin
            rdata = {8'h00, LAST_PIN, 8'h00, VERSION};
        end else if (in_tbl) begin
            rdata = sel[0] ? entry_hi(pick) : entry_lo(pick);
        end
    end

endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int unsigned PINS    = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int unsigned IDX_W  = (PINS > 1) ? $clog2(PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [7:0]          bus_addr,
    input  logic [3:0]          bus_size,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    input  logic [PINS-1:0]     svc_rpend_set,
    input  logic [PINS-1:0]     svc_rpend_clr,
    output logic [PINS*8-1:0]   ent_vector,
    output logic [PINS*3-1:0]   ent_dmode,
    output logic [PINS-1:0]     ent_destmode,
    output logic [PINS-1:0]     ent_pol,
    output logic [PINS-1:0]     ent_trig,
    output logic [PINS-1:0]     ent_mask,
    output logic [PINS-1:0]     ent_rpend,
    output logic [PINS*8-1:0]   ent_dest,
    output logic                upd_pulse,
    output logic [IDX_W-1:0]    upd_index,
    output logic                eoi_valid,
    output logic [7:0]          eoi_vector
);

    typedef struct packed {
        logic [7:0]       sel;
        logic [3:0]       id;
        logic [31:0]      rdata;
        logic             rvalid;
        logic             upd;
        logic [IDX_W-1:0] upd_idx;
        logic             eoi;
        logic [7:0]       eoi_vec;
    } ctl_t;

    ctl_t              st_d;
    ctl_t              st_q;
    acc_e              acc;
    entry_t [PINS-1:0] ents;
    logic [31:0]       win_rdata;
    logic              tbl_wr_en;
    logic              tbl_hit;
    logic [7:0]        tidx;
    logic [7:0]        sel_q;

    assign sel_q = st_q.sel;

    irq_route_busdec u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .size  (bus_size),
        .kind  (acc)
    );

    irq_route_table #(.PINS(PINS), .IDX_W(IDX_W)) u_tbl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (tbl_wr_en),
        .wr_hi  (st_q.sel[0]),
        .wr_idx (tidx[IDX_W-1:0]),
        .wdata  (bus_wdata),
        .rp_set (svc_rpend_set),
        .rp_clr (svc_rpend_clr),
        .ents   (ents)
    );

    irq_route_rdmux #(.PINS(PINS), .IDX_W(IDX_W), .VERSION(VERSION)) u_rd (
        .sel   (st_q.sel),
        .id    (st_q.id),
        .ents  (ents),
        .rdata (win_rdata)
    );

    always_comb begin
        tidx      = tbl_index(st_q.sel);
        tbl_hit   = (st_q.sel >= SEL_TBL) && (32'(tidx) < 32'(PINS));
        tbl_wr_en = 1'b0;

        st_d         = st_q;
        st_d.rdata   = 32'h0;
        st_d.rvalid  = 1'b0;
        st_d.upd     = 1'b0;
        st_d.upd_idx = '0;
        st_d.eoi     = 1'b0;
        st_d.eoi_vec = 8'h0;

        case (acc)
            ACC_SEL_WR: st_d.sel = bus_wdata[7:0];
            ACC_WIN_WR: begin
                if (st_q.sel == SEL_ID) begin
                    st_d.id = bus_wdata[27:24];
                end else if (tbl_hit) begin
                    tbl_wr_en    = 1'b1;
                    st_d.upd     = 1'b1;
                    st_d.upd_idx = tidx[IDX_W-1:0];
                end
            end
            ACC_EOI_WR: begin
                st_d.eoi     = 1'b1;
                st_d.eoi_vec = bus_wdata[7:0];
            end
            ACC_SEL_RD: begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = {24'h0, st_q.sel};
            end
            ACC_WIN_RD: begin
                st_d.rvalid = 1'b1;
                st_d.rdata  = win_rdata;
            end
            ACC_ZERO_RD: st_d.rvalid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata  = st_q.rdata;
    assign bus_rvalid = st_q.rvalid;
    assign upd_pulse  = st_q.upd;
    assign upd_index  = st_q.upd_idx;
    assign eoi_valid  = st_q.eoi;
    assign eoi_vector = st_q.eoi_vec;

    for (genvar g = 0; g < PINS; g++) begin : g_out
        assign ent_vector[g*8 +: 8] = ents[g].vector;
        assign ent_dmode[g*3 +: 3]  = ents[g].dmode;
        assign ent_destmode[g]      = ents[g].destmode;
        assign ent_pol[g]           = ents[g].pol;
        assign ent_trig[g]          = ents[g].trig;
        assign ent_mask[g]          = ents[g].mask;
        assign ent_rpend[g]         = ents[g].rpend;
        assign ent_dest[g*8 +: 8]   = ents[g].dest;
    end

endmodule

// File: rtl/irq_route_regfile_chk.sv
module irq_route_regfile_chk #(
    parameter int unsigned PINS  = 24,
    parameter int unsigned IDX_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_valid,
    input logic             bus_write,
    input logic [7:0]       bus_addr,
    input logic [3:0]       bus_size,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             bus_rvalid,
    input logic [PINS-1:0]  ent_mask,
    input logic [PINS-1:0]  ent_rpend,
    input logic             upd_pulse,
    input logic [IDX_W-1:0] upd_index,
    input logic             eoi_valid,
    input logic [7:0]       eoi_vector,
    input logic [7:0]       sel_q
);

    logic unused_chk;
    assign unused_chk = ^{bus_wdata[31:8], sel_q[7:1]};

    p_read_answers_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write) |=> bus_rvalid);

    p_misaligned_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && bus_addr[3:0] != 4'h0) |=> (bus_rdata == 32'h0));

    p_bad_size_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && bus_size != 4'd4 && bus_size != 4'd8)
        |=> (!upd_pulse && !eoi_valid));

    p_eoi_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(bus_valid && bus_write && bus_addr == 8'h40));

    p_eoi_vector_r9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> (eoi_vector == $past(bus_wdata[7:0])));

    p_update_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> $past(bus_valid && bus_write && bus_addr == 8'h10));

    p_update_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> (32'(upd_index) < 32'(PINS)));

    p_low_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pulse && !$past(sel_q[0])) |-> !ent_rpend[upd_index]);

    p_mask_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_valid && bus_write) |-> $stable(ent_mask));

endmodule

bind irq_route_regfile irq_route_regfile_chk #(.PINS(PINS), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid),
    .ent_mask   (ent_mask),
    .ent_rpend  (ent_rpend),
    .upd_pulse  (upd_pulse),
    .upd_index  (upd_index),
    .eoi_valid  (eoi_valid),
    .eoi_vector (eoi_vector),
    .sel_q      (sel_q)
);

// File: tb/irq_route_regfile_test.sv
module irq_route_regfile_test;

    localparam int N = 24;
    localparam int IW = 5;
    localparam logic [31:0] LO_WMASK = 32'h0001_AFFF;
    localparam logic [31:0] HI_WMASK = 32'hFF00_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_valid = 1'b0;
    logic          bus_write = 1'b0;
    logic [7:0]    bus_addr = 8'h0;
    logic [3:0]    bus_size = 4'd4;
    logic [31:0]   bus_wdata = 32'h0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [N-1:0]  svc_rpend_set = '0;
    logic [N-1:0]  svc_rpend_clr = '0;
    logic [N*8-1:0] ent_vector;
    logic [N*3-1:0] ent_dmode;
    logic [N-1:0]  ent_destmode, ent_pol, ent_trig, ent_mask, ent_rpend;
    logic [N*8-1:0] ent_dest;
    logic          upd_pulse;
    logic [IW-1:0] upd_index;
    logic          eoi_valid;
    logic [7:0]    eoi_vector;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    logic [31:0] m_lo [N];
    logic [31:0] m_hi [N];
    logic [7:0]  m_sel;
    logic [3:0]  m_id;

    logic        c_upd;
    logic [IW-1:0] c_idx;
    logic        c_eoi;
    logic [7:0]  c_vec;
    logic [31:0] rd_val;
    logic        rd_ok;

    always #5 clk = ~clk;

    irq_route_regfile #(.PINS(N), .VERSION(8'h11)) uut (
        .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_size, .bus_wdata,
        .bus_rdata, .bus_rvalid, .svc_rpend_set, .svc_rpend_clr,
        .ent_vector, .ent_dmode, .ent_destmode, .ent_pol, .ent_trig, .ent_mask,
        .ent_rpend, .ent_dest, .upd_pulse, .upd_index, .eoi_valid, .eoi_vector
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_win(input logic [7:0] s);
        int idx;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
        if (s < 8'h10) return 32'h0;
        idx = (int'(s) - 16) >> 1;
        if (idx >= N) return 32'h0;
        return s[0] ? m_hi[idx] : m_lo[idx];
    endfunction

    function automatic logic exp_hit(input logic [7:0] s);
        return (s >= 8'h10) && (((int'(s) - 16) >> 1) < N);
    endfunction

    // apply a window write to the model
    function automatic void model_win(input logic [31:0] d);
        int idx;
        if (m_sel == 8'h00) m_id = d[27:24];
        else if (exp_hit(m_sel)) begin
            idx = (int'(m_sel) - 16) >> 1;
            if (m_sel[0]) m_hi[idx] = d & HI_WMASK;
            else          m_lo[idx] = d & LO_WMASK;
        end
    endfunction

    task automatic bwr(input logic [7:0] a, input logic [3:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        c_upd = upd_pulse; c_idx = upd_index; c_eoi = eoi_valid; c_vec = eoi_vector;
    endtask

    task automatic brd(input logic [7:0] a);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_size = 4'd4;
        @(negedge clk);
        bus_valid = 1'b0;
        rd_val = bus_rdata; rd_ok = bus_rvalid;
    endtask

    task automatic setsel(input logic [7:0] s);
        bwr(8'h00, 4'd4, {24'h0, s});
        m_sel = s;
    endtask

    task automatic win_rd_chk(input string req);
        brd(8'h10);
        chk(req, rd_val, exp_win(m_sel));
    endtask

    task automatic pulse_rp(input int pin, input logic set);
        @(negedge clk);
        if (set) svc_rpend_set[pin] = 1'b1; else svc_rpend_clr[pin] = 1'b1;
        @(negedge clk);
        svc_rpend_set = '0; svc_rpend_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < N; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = 32'h0; end
        m_sel = 8'h0; m_id = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 masks", 32'(ent_mask), 32'(24'hFF_FFFF));
        chk("R1 vectors", ent_vector[31:0], 32'h0);
        brd(8'h00); chk("R1 select", rd_val, 32'h0);
        win_rd_chk("R1 id");
        setsel(8'h10); win_rd_chk("R1 entry0 low");

        // R2 select register
        setsel(8'h5A); brd(8'h00); chk("R2 select readback", rd_val, 32'h5A);
        chk("R11 rvalid", 32'(rd_ok), 32'h1);

        // R3 version
        setsel(8'h01); win_rd_chk("R3 version");
        bwr(8'h10, 4'd4, 32'hFFFF_FFFF);
        chk("R3 write no update", 32'(c_upd), 32'h0);
        win_rd_chk("R3 version after write");

        // R4 identification
        setsel(8'h00); bwr(8'h10, 4'd4, 32'hA500_0000); model_win(32'hA500_0000);
        win_rd_chk("R4 id");
        setsel(8'h02); win_rd_chk("R4 arb id");
        bwr(8'h10, 4'd4, 32'h0F00_0000);
        setsel(8'h00); win_rd_chk("R4 arb write ignored");

        // R5 / R10 entry halves and update pulse
        setsel(8'h16); bwr(8'h10, 4'd4, 32'hFFFF_FFFF); model_win(32'hFFFF_FFFF);
        chk("R10 update low", {31'h0, c_upd}, 32'h1);
        chk("R10 index low", 32'(c_idx), 32'd3);
        chk("R5 vector out", 32'(ent_vector[3*8 +: 8]), 32'hFF);
        chk("R5 fields out", {27'h0, ent_dmode[9 +: 3], ent_pol[3], ent_trig[3]}, 32'h1F);
        win_rd_chk("R5 low readback");
        setsel(8'h17); bwr(8'h10, 4'd4, 32'hDEAD_BEEF); model_win(32'hDEAD_BEEF);
        chk("R10 index high", {26'h0, c_upd, c_idx}, 32'h23);
        chk("R5 dest out", 32'(ent_dest[3*8 +: 8]), 32'hDE);
        win_rd_chk("R5 high readback");
        setsel(8'h3E); bwr(8'h10, 4'd8, 32'h0000_0042); model_win(32'h0000_0042);
        chk("R5 last pin", {26'h0, c_upd, c_idx}, 32'h37);
        chk("R5 last pin unmasked", 32'(ent_mask[23]), 32'h0);

        // R6 remote-pending
        pulse_rp(5, 1'b1);
        chk("R6 set", 32'(ent_rpend[5]), 32'h1);
        m_lo[5] = m_lo[5] | 32'h4000;
        setsel(8'h1A); win_rd_chk("R6 readback bit14");
        setsel(8'h1B); bwr(8'h10, 4'd4, 32'h1100_0000); model_win(32'h1100_0000);
        chk("R6 high keeps flag", 32'(ent_rpend[5]), 32'h1);
        setsel(8'h1A); bwr(8'h10, 4'd4, 32'h0000_0021); model_win(32'h0000_0021);
        chk("R6 low clears flag", 32'(ent_rpend[5]), 32'h0);
        pulse_rp(5, 1'b1); pulse_rp(5, 1'b0);
        chk("R6 svc clear", 32'(ent_rpend[5]), 32'h0);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 8'h10; bus_size = 4'd4;
        bus_wdata = 32'h0000_0033; svc_rpend_set[5] = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; svc_rpend_set = '0;
        model_win(32'h0000_0033);
        chk("R6 write beats set", 32'(ent_rpend[5]), 32'h0);

        // R7 out of range and undefined selects
        setsel(8'h40); bwr(8'h10, 4'd4, 32'h0000_00FF);
        chk("R7 discarded write", 32'(c_upd), 32'h0);
        brd(8'h10); chk("R7 out of range read", rd_val, 32'h0);
        setsel(8'h05); brd(8'h10); chk("R7 undefined select", rd_val, 32'h0);

        // R8 alignment and size
        bwr(8'h04, 4'd4, 32'h0000_0077);
        brd(8'h00); chk("R8 misaligned write ignored", rd_val, 32'h05);
        bwr(8'h00, 4'd2, 32'h0000_0077);
        brd(8'h00); chk("R8 bad size ignored", rd_val, 32'h05);
        setsel(8'h16); brd(8'h11); chk("R8 misaligned read zero", rd_val, 32'h0);
        bwr(8'h10, 4'd1, 32'h0);
        chk("R8 bad size no update", 32'(c_upd), 32'h0);
        win_rd_chk("R8 entry unchanged");

        // R9 end of interrupt
        bwr(8'h40, 4'd4, 32'h1234_56AB);
        chk("R9 eoi", {23'h0, c_eoi, c_vec}, 32'h1AB);
        bwr(8'h40, 4'd3, 32'h0000_0011);
        chk("R9 eoi bad size", 32'(c_eoi), 32'h0);

        // R11 unknown offset
        brd(8'h20); chk("R11 unknown offset", {rd_val[30:0], rd_ok}, 32'h1);

        // random traffic, R5 / R7 / R10
        for (int k = 0; k < 300; k++) begin
            logic [7:0]  s;
            logic [31:0] d;
            logic        h;
            s = 8'($urandom_range(0, 16 + 2 * N + 3));
            d = $urandom();
            setsel(s);
            h = exp_hit(s);
            if ($urandom_range(0, 3) != 0) begin
                bwr(8'h10, ($urandom_range(0, 1) != 0) ? 4'd8 : 4'd4, d);
                model_win(d);
                chk("R10 random update", 32'(c_upd), 32'(h));
            end
            win_rd_chk("R5 random readback");
            if (h) chk("R5 random mask out", 32'(ent_mask[(int'(s) - 16) >> 1]),
                       32'(m_lo[(int'(s) - 16) >> 1][16]));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule